// File: doc/BRIEF.md
# SPI Clock Rate Divider

This block turns a stream of single-cycle reference enables into the serial clock timing for an SPI master. Each time a programmed number of reference enables, the divisor N, has been counted, it emits a one-cycle period strobe. It also drives a level output that stays low for the first half of each period and goes high for the second half.

Three ways of choosing N are offered. The first is a table-like code that steps through divisors in alternating ×1.5 and ×1.33 increments. The second is a 3-bit power-of-two code that starts at divide-by-4. The third is a cascade of a 4-bit linear prescaler and a 4-bit power-of-two postscaler. Every scheme is reduced internally to a linear factor times a power of two. A prescale counter then feeds its carry into a postscale counter as the enable, and both run on one clock. Software picks the scheme and the codes. A new setting is adopted only at a period boundary, or at any time while the divider is stopped.

Top module: `spi_rate_div`

## Requirements
- R1: With `mode_i` = 0 (table scheme), code k in the range 2 to TBL_MAX_CODE gives N = 4·2^((k-2)/2) for even k and N = 6·2^((k-3)/2) for odd k. Over codes 2 to 18 this gives 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128, 192, 256, 384, 512, 768, 1024.
- R2: In the table scheme, codes 0 and 1 both give N = 4, the value of code 2.
- R3: In the table scheme, a code above the parameter TBL_MAX_CODE (16 or 18) gives the N of TBL_MAX_CODE.
- R4: With `mode_i` = 1 (power-of-two scheme), code n on `pow_sel_i` gives N = 4·2^n, which is 4 to 512.
- R5: With `mode_i` = 2 (cascade), N = (p+1)·2^q, where p is `lin_sel_i` and q is `exp_sel_i`. `mode_i` = 3 behaves exactly like `mode_i` = 1.
- R6: Only cycles with `run_i` and `ref_en_i` both high advance the period. `tick_o` is high for one cycle, in the cycle after the reference enable that completes N counts.
- R7: Counting the position in the period from 0 to N-1, `sclk_o` is 0 for positions below N − floor(N/2) and 1 from there on. It changes in the cycle after the enable that moves the position.
- R8: A change of mode or codes while running leaves the current period untouched. The new N applies from the period that starts after the next `tick_o`.
- R9: While `run_i` is low, both counters are held at zero, `tick_o` and `sclk_o` stay 0, and the inputs are sampled every cycle. After `run_i` rises, the first tick comes after N enables.
- R10: After reset, `tick_o` and `sclk_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Divider runs when high; cleared and idle when low |
| ref_en_i | input | 1 | Reference enable, one count per high cycle |
| mode_i | input | 2 | Scheme: 0 table, 1 power-of-two, 2 cascade, 3 as 1 |
| tbl_sel_i | input | 5 | Table-scheme code |
| pow_sel_i | input | 3 | Power-of-two code |
| lin_sel_i | input | 4 | Cascade linear factor minus one |
| exp_sel_i | input | 4 | Cascade power-of-two exponent |
| tick_o | output | 1 | Period strobe |
| sclk_o | output | 1 | Half-period level |

## Verification
The bench builds the divider with TBL_MAX_CODE = 16. This makes the clamp of R3 observable: codes 17 and 31 must both give 512 cycles, while the largest table periods stay short enough to run twice each. The cascade runs with small exponents and with the largest linear factor, including the degenerate N = 1 case and odd N, where the level output is asymmetric. Sparse reference enables, a mid-period reconfiguration and a stop in mid-period are compared cycle by cycle against a position model.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;
    localparam int TBL_W  = 5;
    localparam int POW_W  = 3;
    localparam int LIN_W  = 4;
    localparam int EXP_W  = 4;
    localparam int DIVL_W = LIN_W + 1;
    localparam int CNT_W  = (1 << EXP_W) - 1;

    typedef enum logic [1:0] {
        MODE_TABLE = 2'd0,
        MODE_POW2  = 2'd1,
        MODE_CASC  = 2'd2,
        MODE_ALT   = 2'd3
    } div_mode_e;

    // divisor = lin * 2^exp
    typedef struct packed {
        logic [DIVL_W-1:0] lin;
        logic [EXP_W-1:0]  exp;
    } rate_cfg_t;
endpackage

// File: rtl/spi_div_cfg_map.sv
module spi_div_cfg_map
    import spi_div_pkg::*;
#(
    parameter int TBL_MAX_CODE = 18
) (
    input  logic [1:0]       mode_i,
    input  logic [TBL_W-1:0] tbl_sel_i,
    input  logic [POW_W-1:0] pow_sel_i,
    input  logic [LIN_W-1:0] lin_sel_i,
    input  logic [EXP_W-1:0] exp_sel_i,
    output rate_cfg_t        cfg_o
);
    localparam logic [TBL_W-1:0] TBL_LO = TBL_W'(2);
    localparam logic [TBL_W-1:0] TBL_HI = TBL_W'(TBL_MAX_CODE);

    logic [TBL_W-1:0] k_c;
    rate_cfg_t        tbl_cfg;

    always_comb begin
        // clamp reserved low codes and codes above the legal maximum
        if (tbl_sel_i < TBL_LO)      k_c = TBL_LO;
        else if (tbl_sel_i > TBL_HI) k_c = TBL_HI;
        else                         k_c = tbl_sel_i;

        // odd codes are 3*2^e, even codes are pure powers of two
        if (k_c[0]) begin
            tbl_cfg.lin = DIVL_W'(3);
            tbl_cfg.exp = EXP_W'(k_c >> 1);
        end else begin
            tbl_cfg.lin = DIVL_W'(1);
            tbl_cfg.exp = EXP_W'(k_c >> 1) + EXP_W'(1);
        end

        case (div_mode_e'(mode_i))
            MODE_TABLE: cfg_o = tbl_cfg;
            MODE_CASC: begin
                cfg_o.lin = DIVL_W'(lin_sel_i) + DIVL_W'(1);
                cfg_o.exp = exp_sel_i;
            end
            default: begin
                cfg_o.lin = DIVL_W'(1);
                cfg_o.exp = EXP_W'(pow_sel_i) + EXP_W'(2);
            end
        endcase
    end
endmodule

// File: rtl/spi_div_cfg_hold.sv
module spi_div_cfg_hold
    import spi_div_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      run_i,
    input  logic      wrap_i,
    input  rate_cfg_t cfg_i,
    output rate_cfg_t act_o
);
    typedef struct packed {
        rate_cfg_t act;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // adopt new settings only while stopped or at a period boundary
        if (!run_i || wrap_i) st_d.act = cfg_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.act.lin <= DIVL_W'(1);
            st_q.act.exp <= EXP_W'(2);
        end else begin
            st_q <= st_d;
        end
    end

    assign act_o = st_q.act;

    // R8: the active setting only moves when stopped or at a boundary
    p_cfg_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(run_i) && !$past(wrap_i)) |-> $stable(st_q.act));
endmodule

// File: rtl/spi_div_prescale.sv
module spi_div_prescale
    import spi_div_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              ref_en_i,
    input  logic [DIVL_W-1:0] lin_i,
    output logic              carry_o,
    output logic [LIN_W-1:0]  cnt_nxt_o
);
    typedef struct packed {
        logic [LIN_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic    last_c;

    always_comb begin
        st_d    = st_q;
        carry_o = 1'b0;
        last_c  = (DIVL_W'(st_q.cnt) == (lin_i - DIVL_W'(1)));
        if (!run_i) begin
            st_d.cnt = '0;
        end else if (ref_en_i) begin
            if (last_c) begin
                st_d.cnt = '0;
                carry_o  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + LIN_W'(1);
            end
        end
        cnt_nxt_o = st_d.cnt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R5: linear stage never reaches its modulus
    p_pre_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        DIVL_W'(st_q.cnt) < lin_i);

    // R9: stopped divider clears the linear stage
    p_pre_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (st_q.cnt == '0));
endmodule

// File: rtl/spi_div_postscale.sv
module spi_div_postscale
    import spi_div_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              carry_i,
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [DIVL_W-1:0] lin_i,
    input  logic [LIN_W-1:0]  pre_nxt_i,
    output logic              wrap_o,
    output logic              tick_o,
    output logic              sclk_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
        logic             lvl;
    } post_st_t;

    post_st_t         st_d, st_q;
    logic [CNT_W:0]   span_c;
    logic [CNT_W-1:0] mask_c;

    always_comb begin
        st_d   = st_q;
        span_c = (CNT_W + 1)'(1) << exp_i;
        mask_c = CNT_W'(span_c - (CNT_W + 1)'(1));
        wrap_o = carry_i && (st_q.cnt == mask_c);

        if (!run_i)       st_d.cnt = '0;
        else if (wrap_o)  st_d.cnt = '0;
        else if (carry_i) st_d.cnt = st_q.cnt + CNT_W'(1);

        st_d.tick = wrap_o;

        // second half of the period drives the level high
        if (exp_i != '0)
            st_d.lvl = st_d.cnt[exp_i - EXP_W'(1)];
        else
            st_d.lvl = (DIVL_W'(pre_nxt_i) >= (lin_i - (lin_i >> 1)));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tick_o = st_q.tick;
    assign sclk_o = st_q.lvl;

    // R6: a period strobe always follows a linear-stage carry
    p_tick_after_carry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |-> $past(carry_i));

    // R9: stopped divider is silent and cleared
    p_post_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (!tick_o && !sclk_o && st_q.cnt == '0));

    // R5: power-of-two stage stays inside its 2^exp window
    p_post_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cnt >> exp_i) == '0);
endmodule

// File: rtl/spi_rate_div.sv
module spi_rate_div
    import spi_div_pkg::*;
#(
    parameter int TBL_MAX_CODE = 18
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             ref_en_i,
    input  logic [1:0]       mode_i,
    input  logic [TBL_W-1:0] tbl_sel_i,
    input  logic [POW_W-1:0] pow_sel_i,
    input  logic [LIN_W-1:0] lin_sel_i,
    input  logic [EXP_W-1:0] exp_sel_i,
    output logic             tick_o,
    output logic             sclk_o
);
    rate_cfg_t        req_cfg;
    rate_cfg_t        act_cfg;
    logic             carry;
    logic             wrap;
    logic [LIN_W-1:0] pre_nxt;

    spi_div_cfg_map #(.TBL_MAX_CODE(TBL_MAX_CODE)) u_map (
        .mode_i    (mode_i),
        .tbl_sel_i (tbl_sel_i),
        .pow_sel_i (pow_sel_i),
        .lin_sel_i (lin_sel_i),
        .exp_sel_i (exp_sel_i),
        .cfg_o     (req_cfg)
    );

    spi_div_cfg_hold u_hold (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run_i),
        .wrap_i (wrap),
        .cfg_i  (req_cfg),
        .act_o  (act_cfg)
    );

    spi_div_prescale u_pre (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (run_i),
        .ref_en_i  (ref_en_i),
        .lin_i     (act_cfg.lin),
        .carry_o   (carry),
        .cnt_nxt_o (pre_nxt)
    );

    spi_div_postscale u_post (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (run_i),
        .carry_i   (carry),
        .exp_i     (act_cfg.exp),
        .lin_i     (act_cfg.lin),
        .pre_nxt_i (pre_nxt),
        .wrap_o    (wrap),
        .tick_o    (tick_o),
        .sclk_o    (sclk_o)
    );
endmodule

// File: tb/tb_spi_rate_div.sv
module tb_spi_rate_div;
    localparam int TBLMAX = 16;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       run_i = 1'b0;
    logic       ref_en_i = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic [4:0] tbl_sel_i = 5'd0;
    logic [2:0] pow_sel_i = 3'd0;
    logic [3:0] lin_sel_i = 4'd0;
    logic [3:0] exp_sel_i = 4'd0;
    logic       tick_o;
    logic       sclk_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    bit    exp_tick_q[$];
    bit    exp_lvl_q[$];
    string tag_q[$];
    string cur_tag = "R10";

    int pos = 0;
    int act_n = 4;

    spi_rate_div #(.TBL_MAX_CODE(TBLMAX)) dut (
        .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .ref_en_i(ref_en_i),
        .mode_i(mode_i), .tbl_sel_i(tbl_sel_i), .pow_sel_i(pow_sel_i),
        .lin_sel_i(lin_sel_i), .exp_sel_i(exp_sel_i),
        .tick_o(tick_o), .sclk_o(sclk_o)
    );

    always #10 clk_i = ~clk_i;

    // expected divisor from the requirement text
    function automatic int want_div(int m, int tc, int pc, int lc, int ec);
        int k;
        if (m == 2) return (lc + 1) << ec;
        if (m != 0) return 4 << pc;
        k = (tc < 2) ? 2 : ((tc > TBLMAX) ? TBLMAX : tc);
        case (k)
            2: return 4;     3: return 6;     4: return 8;     5: return 12;
            6: return 16;    7: return 24;    8: return 32;    9: return 48;
            10: return 64;   11: return 96;   12: return 128;  13: return 192;
            14: return 256;  15: return 384;  16: return 512;  17: return 768;
            default: return 1024;
        endcase
    endfunction

    function automatic int cur_div();
        return want_div(int'(mode_i), int'(tbl_sel_i), int'(pow_sel_i),
                        int'(lin_sel_i), int'(exp_sel_i));
    endfunction

    // driver: one cycle of stimulus, expected outputs pushed after the edge
    task automatic step(bit r, bit f);
        bit et;
        run_i    = r;
        ref_en_i = f;
        et = 1'b0;
        if (!r) begin
            pos   = 0;
            act_n = cur_div();
        end else if (f) begin
            if (pos + 1 >= act_n) begin
                pos   = 0;
                et    = 1'b1;
                act_n = cur_div();
            end else begin
                pos++;
            end
        end
        @(posedge clk_i);
        exp_tick_q.push_back(et);
        exp_lvl_q.push_back(pos >= act_n - act_n / 2);
        tag_q.push_back(cur_tag);
        #1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0);
    endtask

    task automatic run_for(int n, int gap);
        for (int i = 0; i < n; i++) step(1'b1, (i % gap) == gap - 1);
    endtask

    // monitor: compare outputs mid-cycle against the queue
    always @(negedge clk_i) begin
        if (exp_tick_q.size() > 0) begin
            bit    et, el;
            string tg;
            et = exp_tick_q.pop_front();
            el = exp_lvl_q.pop_front();
            tg = tag_q.pop_front();
            compared += 2;
            if (tick_o !== et) begin
                mismatched++;
                $display("FAIL %s (R6) tick_o actual %b expected %b at %0t", tg, tick_o, et, $time);
            end
            if (sclk_o !== el) begin
                mismatched++;
                $display("FAIL %s (R7) sclk_o actual %b expected %b at %0t", tg, sclk_o, el, $time);
            end
        end
    end

    task automatic table_case(int code);
        mode_i    = 2'd0;
        tbl_sel_i = 5'(code);
        if (code < 2)           cur_tag = "R2";
        else if (code > TBLMAX) cur_tag = "R3";
        else                    cur_tag = "R1";
        idle(2);
        run_for(2 * cur_div() + 3, 1);
    endtask

    initial begin
        int codes[11] = '{0, 1, 2, 3, 4, 5, 9, 12, 16, 17, 31};
        repeat (3) @(posedge clk_i);
        #1 rst_ni = 1'b1;
        @(negedge clk_i);
        // R10: reset state
        compared++;
        if (tick_o !== 1'b0 || sclk_o !== 1'b0) begin
            mismatched++;
            $display("FAIL R10 reset outputs actual %b%b expected 00", tick_o, sclk_o);
        end
        @(posedge clk_i); #1;

        foreach (codes[i]) table_case(codes[i]);

        // R4: power-of-two scheme
        cur_tag = "R4";
        mode_i = 2'd1;
        for (int n = 0; n < 4; n++) begin
            pow_sel_i = 3'(n);
            idle(2);
            run_for(2 * cur_div() + 3, 1);
        end

        // R5: cascade, including N=1 and odd N
        cur_tag = "R5";
        mode_i = 2'd2;
        for (int c = 0; c < 6; c++) begin
            int pl[6] = '{0, 2, 4, 15, 3, 6};
            int ql[6] = '{0, 0, 2, 1, 3, 1};
            lin_sel_i = 4'(pl[c]);
            exp_sel_i = 4'(ql[c]);
            idle(2);
            run_for(2 * cur_div() + 3, 1);
        end
        // R5: mode 3 behaves as power-of-two
        mode_i = 2'd3;
        pow_sel_i = 3'd2;
        idle(2);
        run_for(2 * cur_div() + 3, 1);

        // R6: sparse reference enables
        cur_tag = "R6";
        mode_i = 2'd1;
        pow_sel_i = 3'd0;
        idle(2);
        run_for(40, 3);

        // R7: odd divisor with gapped enables
        cur_tag = "R7";
        mode_i = 2'd2;
        lin_sel_i = 4'd2;
        exp_sel_i = 4'd0;
        idle(2);
        run_for(30, 2);

        // R8: change while running applies after the next boundary
        cur_tag = "R8";
        mode_i = 2'd0;
        tbl_sel_i = 5'd2;
        idle(2);
        run_for(6, 1);
        mode_i = 2'd1;
        pow_sel_i = 3'd1;
        run_for(22, 1);

        // R9: stop in mid-period then restart
        cur_tag = "R9";
        mode_i = 2'd1;
        pow_sel_i = 3'd2;
        idle(2);
        run_for(7, 1);
        idle(3);
        run_for(40, 1);
        idle(2);

        @(negedge clk_i);
        @(negedge clk_i);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_i);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired, actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule